// File: doc/BRIEF.md
# Write-Only Two-Wire Register Loader

This block is a target on a two-wire serial bus (I2C) that only accepts writes. It listens for one fixed device address byte, `1010_1000`. The first byte after that address sets an internal register pointer. Each byte after that is handed to a register bank through a one-cycle write strobe, with the 8-bit address and the 8-bit data. The pointer then moves on by one, so a burst of data bytes fills consecutive registers.

The block samples both bus lines with the system clock. Each line passes through a two-flop synchroniser, and bus events are found by comparing each synchronised level with its value one cycle earlier. The system clock must run at least 16 times the SCL rate, so up to 400 kHz needs 6.4 MHz or more. The block pulls SDA low through an open-drain enable output when it acknowledges. It never stretches the clock and never returns data.

The controller has eight named states:
- `ST_IDLE` waits for a START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` acknowledges a matching address byte.
- `ST_PTR` shifts in the pointer byte.
- `ST_PTR_ACK` acknowledges the pointer byte.
- `ST_DATA` shifts in a data byte.
- `ST_DATA_ACK` acknowledges a data byte.
- `ST_SKIP` ignores the bus after an address byte that does not match.

The transitions are:
- START moves from any state to `ST_ADDR`.
- STOP moves from any state to `ST_IDLE`.
- A completed address byte moves `ST_ADDR` to `ST_ADDR_ACK` if it matches, or to `ST_SKIP` if it does not.
- The end of the ninth clock moves each ACK state on: `ST_ADDR_ACK` to `ST_PTR`, `ST_PTR_ACK` to `ST_DATA`, and `ST_DATA_ACK` back to `ST_DATA`.
- A completed byte moves `ST_PTR` to `ST_PTR_ACK` and `ST_DATA` to `ST_DATA_ACK`.

Top module: `twi_reg_writer`

## Requirements
- R1: During and right after reset, `wr_en` is low and `sda_oe` is low (SDA released).
- R2: A START (SDA falls while SCL is high) begins address reception. A STOP (SDA rises while SCL is high) returns the block to idle. Bytes clocked in idle, without a new START, get no acknowledge and no write.
- R3: The block acknowledges the address byte only when all 8 bits, R/W included, equal `1010_1000`. Any other byte gets no acknowledge, including `1010_1001` (the read form). After such a byte, the block ignores the bus until the next START.
- R4: The block samples a bit on each rising SCL edge. Bytes arrive most significant bit first.
- R5: After the address byte, the pointer byte and each data byte, `sda_oe` is high through the whole ninth SCL clock. It rises and falls only while SCL is low.
- R6: The first byte after an accepted address loads the register pointer, is acknowledged, and produces no write.
- R7: Each data byte causes a write to the current pointer. The pointer then increments by one and wraps from `0xFF` to `0x00`.
- R8: A repeated START inside a transfer discards any partly received byte without a write. The block releases SDA and restarts address reception.
- R9: `wr_en` is high for exactly one system clock. It rises 3 system clocks after the raw SCL input falls at the end of a data byte's eighth bit: two synchroniser stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High to pull SDA low (open-drain acknowledge) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
Each SCL fall reaches the state machine after two synchroniser stages, so the write strobe appears exactly 3 system clocks after the raw SCL fall that ends a data byte. The bench records the cycle of every SCL fall it drives, and its monitor requires exactly that gap whenever it pops an expected write from the scoreboard. The acknowledge starts about three clocks after the eighth SCL fall and ends about three clocks after the ninth. The bench therefore samples SDA in the middle of the ninth high phase, 10 clocks after the rise, well clear of both edges.

// File: rtl/twi_pkg.sv
package twi_pkg;

    // Controller states of the write-only bus target
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } twi_state_t;

    // Index of each bus line inside the synchroniser vector
    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;
    localparam int unsigned LINE_CNT = 2;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Idle bus lines are high, so reset to 1 to avoid false edges
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign level[g] = chain_q[STAGES-1];
        assign rise[g]  = chain_q[STAGES-1] & ~prev_q;
        assign fall[g]  = ~chain_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/twi_bit_shifter.sv
module twi_bit_shifter #(
    parameter int unsigned BITS = 8,
    localparam int unsigned CW  = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift,
    input  logic            bit_in,
    output logic [BITS-1:0] byte_o,
    output logic [CW-1:0]   count_o
);

    logic [BITS-1:0] sreg_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            cnt_q  <= '0;
        end else if (shift) begin
            // Most significant bit arrives first
            sreg_q <= {sreg_q[BITS-2:0], bit_in};
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign byte_o  = sreg_q;
    assign count_o = cnt_q;

endmodule

// File: rtl/twi_reg_writer.sv
module twi_reg_writer
    import twi_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter logic [7:0]  DEV_ADDR    = 8'b1010_1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int unsigned CW = $clog2(BYTE_W + 1);

    logic [LINE_CNT-1:0] line_lvl;
    logic [LINE_CNT-1:0] line_rise;
    logic [LINE_CNT-1:0] line_fall;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    twi_state_t state_q, state_d;
    logic [BYTE_W-1:0] ptr_q;
    logic [BYTE_W-1:0] rx_byte;
    logic [CW-1:0]     bit_cnt;
    logic              byte_done, ack_done, in_ack, sh_clear, sh_shift;
    logic              ack_next;

    twi_line_sync #(
        .WIDTH  (LINE_CNT),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sda_i, scl_i}),
        .level (line_lvl),
        .rise  (line_rise),
        .fall  (line_fall)
    );

    assign scl_lvl  = line_lvl[LINE_SCL];
    assign scl_rise = line_rise[LINE_SCL];
    assign scl_fall = line_fall[LINE_SCL];
    assign sda_lvl  = line_lvl[LINE_SDA];
    assign sda_rise = line_rise[LINE_SDA];
    assign sda_fall = line_fall[LINE_SDA];

    // Bus conditions: SDA moving while SCL is high
    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;

    assign in_ack = (state_q == ST_ADDR_ACK) || (state_q == ST_PTR_ACK) ||
                    (state_q == ST_DATA_ACK);

    // A byte ends on the SCL fall after its eighth rise; the ACK slot
    // ends on the SCL fall after its single rise.
    assign byte_done = scl_fall && (bit_cnt == CW'(BYTE_W)) && !in_ack;
    assign ack_done  = scl_fall && (bit_cnt == CW'(1)) && in_ack;

    assign sh_clear = start_det | stop_det | byte_done | ack_done;
    assign sh_shift = scl_rise && (state_q != ST_IDLE) && (state_q != ST_SKIP);

    twi_bit_shifter #(
        .BITS (BYTE_W)
    ) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sh_clear),
        .shift   (sh_shift),
        .bit_in  (sda_lvl),
        .byte_o  (rx_byte),
        .count_o (bit_cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (byte_done) begin
                        state_d = (rx_byte == BYTE_W'(DEV_ADDR)) ? ST_ADDR_ACK : ST_SKIP;
                    end
                end
                ST_ADDR_ACK: if (ack_done)  state_d = ST_PTR;
                ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  if (ack_done)  state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (ack_done)  state_d = ST_DATA;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (!start_det && !stop_det && byte_done) begin
                if (state_q == ST_PTR) begin
                    ptr_q <= rx_byte;
                end else if (state_q == ST_DATA) begin
                    ptr_q <= ptr_q + BYTE_W'(1);
                end
            end
        end
    end

    assign ack_next = (state_d == ST_ADDR_ACK) || (state_d == ST_PTR_ACK) ||
                      (state_d == ST_DATA_ACK);

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            sda_oe <= ack_next;
            wr_en  <= 1'b0;
            if ((state_q == ST_DATA) && byte_done && !start_det && !stop_det) begin
                wr_en   <= 1'b1;
                wr_addr <= ptr_q;
                wr_data <= rx_byte;
            end
        end
    end

endmodule

// File: rtl/twi_reg_writer_chk.sv
module twi_reg_writer_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              scl_fall,
    input logic              start_det,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] ptr_q
);

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R9

    AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_fall)); // R9

    AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_lvl); // R5

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr_q == BYTE_W'(wr_addr + BYTE_W'(1)))); // R7

    AST_START_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R8

    AST_NO_STROBE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !wr_en); // R8

endmodule

bind twi_reg_writer twi_reg_writer_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ptr_q     (ptr_q)
);

// File: tb/test_twi_reg_writer.sv
module test_twi_reg_writer;

    localparam int HALF = 20;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
    } wr_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    int cyc = 0;
    int fall_cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    wr_item_t expq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Open-drain wiring: either side can pull SDA low
    assign sda_line = sda_drv & ~sda_oe;

    twi_reg_writer i_twi_reg_writer (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_drv),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1;
        wait_cyc(4);
        scl_drv = 1'b1;
        wait_cyc(HALF);
        sda_drv = 1'b0;
        wait_cyc(HALF);
        scl_drv = 1'b0;
        fall_cyc = cyc;
        wait_cyc(4);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0;
        wait_cyc(4);
        scl_drv = 1'b1;
        wait_cyc(HALF);
        sda_drv = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b;
        wait_cyc(HALF - 4);
        scl_drv = 1'b1;
        wait_cyc(HALF);
        scl_drv = 1'b0;
        fall_cyc = cyc;
        wait_cyc(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1;
        wait_cyc(HALF - 4);
        scl_drv = 1'b1;
        wait_cyc(HALF / 2);
        acked = (sda_line == 1'b0);
        wait_cyc(HALF / 2);
        scl_drv = 1'b0;
        fall_cyc = cyc;
        wait_cyc(4);
    endtask

    // Full write: address, pointer, then data bytes; scoreboard gets expectations
    task automatic write_burst(input logic [7:0] ptr, input logic [7:0] dat[$]);
        bit ack;
        bus_start();
        send_byte(8'hA8, ack);
        check(ack, "R3", "address ack", ack, 1);
        send_byte(ptr, ack);
        check(ack, "R6", "pointer ack", ack, 1);
        foreach (dat[i]) begin
            expq.push_back('{a: 8'(ptr + 8'(i)), d: dat[i]});
            send_byte(dat[i], ack);
            check(ack, "R5", "data ack", ack, 1);
        end
        bus_stop();
        wait_cyc(10);
        check(expq.size() == 0, "R7", "pending writes after burst", expq.size(), 0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6", "unexpected write addr", int'(wr_addr), -1);
            end else begin
                wr_item_t e;
                e = expq.pop_front();
                check(wr_addr == e.a, "R7", "write address", wr_addr, e.a);
                check(wr_data == e.d, "R4", "write data", wr_data, e.d);
                check(cyc - fall_cyc == 3, "R9", "strobe latency", cyc - fall_cyc, 3);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        wait_cyc(5);
        check(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
        check(sda_oe == 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wait_cyc(5);
        check(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);

        // Single write
        write_burst(8'h05, '{8'h3C});
        // Burst with bit-order patterns
        write_burst(8'h10, '{8'h01, 8'h80, 8'hA5, 8'h00, 8'hFF});
        // Pointer wrap
        write_burst(8'hFE, '{8'h5A, 8'hA5, 8'h77});

        // Wrong address: nack and everything ignored (R3)
        bus_start();
        send_byte(8'hA0, ack);
        check(!ack, "R3", "wrong address nack", ack, 0);
        send_byte(8'h02, ack);
        check(!ack, "R3", "byte after wrong address", ack, 0);
        send_byte(8'h44, ack);
        check(!ack, "R3", "data after wrong address", ack, 0);
        bus_stop();

        // Read form of the address: nack (R3)
        bus_start();
        send_byte(8'hA9, ack);
        check(!ack, "R3", "read address nack", ack, 0);
        send_byte(8'h03, ack);
        check(!ack, "R3", "byte after read address", ack, 0);
        bus_stop();

        // Repeated start mid-byte discards the partial byte (R8)
        bus_start();
        send_byte(8'hA8, ack);
        check(ack, "R3", "address ack before restart", ack, 1);
        send_byte(8'h20, ack);
        check(ack, "R6", "pointer ack before restart", ack, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        check(sda_oe == 1'b0, "R8", "sda released after restart", sda_oe, 0);
        send_byte(8'hA8, ack);
        check(ack, "R8", "address ack after restart", ack, 1);
        send_byte(8'h30, ack);
        expq.push_back('{a: 8'h30, d: 8'h77});
        send_byte(8'h77, ack);
        check(ack, "R8", "data ack after restart", ack, 1);
        bus_stop();
        wait_cyc(10);
        check(expq.size() == 0, "R8", "pending writes after restart", expq.size(), 0);

        // Bytes in idle without START are ignored (R2)
        scl_drv = 1'b0;
        wait_cyc(10);
        send_byte(8'hA8, ack);
        check(!ack, "R2", "address in idle nack", ack, 0);
        send_byte(8'h40, ack);
        check(!ack, "R2", "byte in idle nack", ack, 0);
        bus_stop();
        wait_cyc(10);
        check(sda_oe == 1'b0, "R2", "sda released in idle", sda_oe, 0);

        // Bus still usable afterwards
        write_burst(8'h7F, '{8'h12, 8'h34});

        check(expq.size() == 0, "R7", "final scoreboard empty", expq.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule